// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits in front of the instruction issue stage of a multithreaded compute unit. A launch request carries a thread count and a start address. When it is accepted, the scheduler cuts the group of threads into 32-lane warps. It places each warp in a free slot of its warp table and tags it with a free group slot. Each warp keeps its own program counter and a lane mask that shows which of its lanes hold real threads.

Readiness comes from outside the block, as does the stall and completion status of each warp. In every cycle the scheduler looks at the warps that are resident, ready and not stalled. It picks one of them by rotating priority and presents that warp's index, program counter and lane mask on the issue port in the same cycle. The chosen warp's counter then steps to its next instruction. When a warp reports completion, its slot is released. A group slot is released once the last of its warps has completed.

Launches are admitted only when they fit inside the residency limits: 24 warp slots and 8 group slots.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held, and right after it, no warp is resident. `issue_valid` is low even with every ready bit set, and `launch_ready` is high for a request of a legal size.
- R2: An accepted launch of T threads creates ceil(T/32) warps, and each of them starts at `launch_pc`. Warp k of the group takes the k-th lowest-numbered free slot, so `issue_warp` gives the slot index.
- R3: Bit l of `issue_mask` stands for lane l. Every warp of a group has all 32 bits set, except the last warp when T mod 32 is not zero. That warp has only its low (T mod 32) bits set.
- R4: A warp can be issued only when it is resident, its `warp_ready` bit is high and its `warp_stall` bit is low. A stalled or unready warp never holds back another warp that can be issued. With no such warp, `issue_valid` is low in that cycle.
- R5: The search for the next warp starts at the slot just above the warp issued last, wrapping from 23 to 0. After reset it starts at slot 0.
- R6: The issue outputs follow the inputs within the same cycle. Each issue moves that warp's program counter forward by 4, and the new value is seen from its next issue on.
- R7: A launch is held off (`launch_ready` low) when fewer free warp slots are left than the request needs.
- R8: A launch is held off when all 8 group slots are in use, even if warp slots are free.
- R9: A warp whose `warp_done` bit is high leaves the table at the next clock edge and cannot be issued afterwards. Its group slot returns to the pool once every warp of that group has completed, so a new launch can then take it.
- R10: A request for 0 threads, or for more than 512 threads, is never accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request present |
| launch_threads | input | 10 | Thread count of the request |
| launch_pc | input | 32 | Start address shared by all warps of the request |
| launch_ready | output | 1 | Request can be accepted in this cycle |
| warp_ready | input | 24 | Per-slot: next instruction is ready |
| warp_stall | input | 24 | Per-slot: warp is held back |
| warp_done | input | 24 | Per-slot: warp has finished |
| issue_valid | output | 1 | A warp is issued in this cycle |
| issue_warp | output | 5 | Slot index of the issued warp |
| issue_pc | output | 32 | Program counter of the issued warp |
| issue_mask | output | 32 | Active-lane mask of the issued warp |

## Verification
The bench drives a group of 40 threads. A design that fills the last warp's mask from the wrong end, or fills it completely, shows the wrong low-order bits on the second warp. It then moves between two warps far apart in the table. A priority pointer that restarts at zero, instead of after the last winner, picks the same warp twice. It fills the warp table to within six slots and then the group table to all eight, and checks that each limit alone holds off a launch. A design that counts only one of the two resources would accept. Last, it releases the second warp of a group and expects the freed group slot and the lowest free warp slot to be reused at once. A design that frees the group on its first completion, or never frees it, gives the wrong admission result or the wrong slot.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // Admission outcome for a launch request
  typedef enum logic [1:0] {
    ADM_OK        = 2'd0,
    ADM_BAD_SIZE  = 2'd1,
    ADM_NO_WARPS  = 2'd2,
    ADM_NO_BLOCK  = 2'd3
  } admit_e;

  // Index width with a floor of one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wis_alloc.sv
module wis_alloc
  import wis_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int NW     = 24,
  parameter int NB     = 8,
  parameter int MAXT   = 512,
  parameter int TCNT_W = 10,
  parameter int BID_W  = 3
) (
  input  logic [NW-1:0]            warp_valid,
  input  logic [NB-1:0]            blk_busy,
  input  logic [TCNT_W-1:0]        req_threads,
  output logic                     admit_ok,
  output logic [NW-1:0]            slot_take,
  output logic [NW-1:0][LANES-1:0] slot_mask,
  output logic [BID_W-1:0]         blk_pick
);

  admit_e admit_why;
  int     need;
  int     tail;
  int     rank;
  logic   blk_found;

  always_comb begin
    need      = (int'(req_threads) + LANES - 1) / LANES;
    tail      = int'(req_threads) % LANES;
    rank      = 0;
    slot_take = '0;
    slot_mask = '0;
    // free slots are handed out lowest index first, in warp order
    for (int i = 0; i < NW; i++) begin
      if (!warp_valid[i]) begin
        if (rank < need) begin
          slot_take[i] = 1'b1;
          for (int l = 0; l < LANES; l++) begin
            slot_mask[i][l] = (rank != need - 1) || (tail == 0) || (l < tail);
          end
        end
        rank = rank + 1;
      end
    end

    blk_found = 1'b0;
    blk_pick  = '0;
    for (int b = 0; b < NB; b++) begin
      if (!blk_found && !blk_busy[b]) begin
        blk_found = 1'b1;
        blk_pick  = BID_W'(b);
      end
    end

    if (req_threads == '0 || int'(req_threads) > MAXT) admit_why = ADM_BAD_SIZE;
    else if (rank < need)                              admit_why = ADM_NO_WARPS;
    else if (!blk_found)                               admit_why = ADM_NO_BLOCK;
    else                                               admit_why = ADM_OK;

    admit_ok = (admit_why == ADM_OK);
  end

endmodule

// File: rtl/wis_arbiter.sv
module wis_arbiter #(
  parameter int NW    = 24,
  parameter int WID_W = 5
) (
  input  logic [NW-1:0]    elig,
  input  logic [WID_W-1:0] last,
  output logic             gnt_valid,
  output logic [WID_W-1:0] gnt_idx
);

  int cand;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    cand      = 0;
    // rotating priority: first candidate is the slot after the last winner
    for (int k = 1; k <= NW; k++) begin
      cand = int'(last) + k;
      if (cand >= NW) cand = cand - NW;
      if (!gnt_valid && elig[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = WID_W'(cand);
      end
    end
  end

endmodule

// File: rtl/wis_warp_table.sv
module wis_warp_table #(
  parameter int NW      = 24,
  parameter int NB      = 8,
  parameter int LANES   = 32,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter int BID_W   = 3,
  parameter int WID_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch_fire,
  input  logic [PC_W-1:0]          launch_pc,
  input  logic [NW-1:0]            slot_take,
  input  logic [NW-1:0][LANES-1:0] slot_mask,
  input  logic [BID_W-1:0]         blk_pick,
  input  logic                     issue_fire,
  input  logic [WID_W-1:0]         issue_idx,
  input  logic [NW-1:0]            warp_done,
  output logic [NW-1:0]            warp_valid,
  output logic [NW-1:0][PC_W-1:0]  warp_pc,
  output logic [NW-1:0][LANES-1:0] warp_mask,
  output logic [NB-1:0]            blk_busy
);

  logic [NW-1:0]            valid_q, valid_d;
  logic [NW-1:0][PC_W-1:0]  pc_q, pc_d;
  logic [NW-1:0][LANES-1:0] mask_q;
  logic [NW-1:0][BID_W-1:0] blk_q;
  logic [NW-1:0]            pc_en, ld_en;

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < NW; i++) begin
      pc_en[i] = 1'b0;
      pc_d[i]  = pc_q[i];
      ld_en[i] = launch_fire & slot_take[i];
      if (warp_done[i]) valid_d[i] = 1'b0;
      if (issue_fire && issue_idx == WID_W'(i)) begin
        pc_en[i] = 1'b1;
        pc_d[i]  = pc_q[i] + PC_W'(PC_STEP);
      end
      if (ld_en[i]) begin
        valid_d[i] = 1'b1;
        pc_en[i]   = 1'b1;
        pc_d[i]    = launch_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < NW; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (pc_en[g]) pc_q[g] <= pc_d[g];
      if (ld_en[g]) begin
        mask_q[g] <= slot_mask[g];
        blk_q[g]  <= blk_pick;
      end
    end
  end

  always_comb begin
    blk_busy = '0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NW; i++) begin
        if (valid_q[i] && blk_q[i] == BID_W'(b)) blk_busy[b] = 1'b1;
      end
    end
  end

  assign warp_valid = valid_q;
  assign warp_pc    = pc_q;
  assign warp_mask  = mask_q;

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int LANES             = 32,
  parameter int MAX_WARPS         = 24,
  parameter int MAX_BLOCKS        = 8,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int PC_W              = 32,
  parameter int PC_STEP           = 4,
  localparam int TCNT_W           = $clog2(MAX_BLOCK_THREADS + 1),
  localparam int WID_W            = idx_w(MAX_WARPS),
  localparam int BID_W            = idx_w(MAX_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [TCNT_W-1:0]    launch_threads,
  input  logic [PC_W-1:0]      launch_pc,
  output logic                 launch_ready,
  input  logic [MAX_WARPS-1:0] warp_ready,
  input  logic [MAX_WARPS-1:0] warp_stall,
  input  logic [MAX_WARPS-1:0] warp_done,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [PC_W-1:0]      issue_pc,
  output logic [LANES-1:0]     issue_mask
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [MAX_WARPS-1:0]            warp_valid;
  logic [MAX_WARPS-1:0][PC_W-1:0]  warp_pc;
  logic [MAX_WARPS-1:0][LANES-1:0] warp_mask;
  logic [MAX_BLOCKS-1:0]           blk_busy;
  logic [MAX_WARPS-1:0]            slot_take;
  logic [MAX_WARPS-1:0][LANES-1:0] slot_mask;
  logic [BID_W-1:0]                blk_pick;
  logic                            admit_ok;
  logic                            launch_fire;
  logic [MAX_WARPS-1:0]            elig;
  logic                            gnt_valid;
  logic [WID_W-1:0]                gnt_idx;
  logic [WID_W-1:0]                last_q, last_d;

  wis_alloc #(
    .LANES(LANES), .NW(MAX_WARPS), .NB(MAX_BLOCKS),
    .MAXT(MAX_BLOCK_THREADS), .TCNT_W(TCNT_W), .BID_W(BID_W)
  ) u_alloc (
    .warp_valid (warp_valid),
    .blk_busy   (blk_busy),
    .req_threads(launch_threads),
    .admit_ok   (admit_ok),
    .slot_take  (slot_take),
    .slot_mask  (slot_mask),
    .blk_pick   (blk_pick)
  );

  assign launch_ready = admit_ok;
  assign launch_fire  = launch_valid & admit_ok;

  wis_warp_table #(
    .NW(MAX_WARPS), .NB(MAX_BLOCKS), .LANES(LANES), .PC_W(PC_W),
    .PC_STEP(PC_STEP), .BID_W(BID_W), .WID_W(WID_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .launch_fire(launch_fire),
    .launch_pc  (launch_pc),
    .slot_take  (slot_take),
    .slot_mask  (slot_mask),
    .blk_pick   (blk_pick),
    .issue_fire (gnt_valid),
    .issue_idx  (gnt_idx),
    .warp_done  (warp_done),
    .warp_valid (warp_valid),
    .warp_pc    (warp_pc),
    .warp_mask  (warp_mask),
    .blk_busy   (blk_busy)
  );

  assign elig = warp_valid & warp_ready & ~warp_stall;

  wis_arbiter #(.NW(MAX_WARPS), .WID_W(WID_W)) u_arb (
    .elig     (elig),
    .last     (last_q),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx)
  );

  always_comb begin
    last_d = last_q;
    if (gnt_valid) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) last_q <= WID_W'(MAX_WARPS - 1);
    else            last_q <= last_d;
  end

  assign issue_valid = gnt_valid;
  assign issue_warp  = gnt_idx;
  assign issue_pc    = warp_pc[gnt_idx];
  assign issue_mask  = warp_mask[gnt_idx];

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NW     = 24,
  parameter int NB     = 8,
  parameter int LANES  = 32,
  parameter int MAXT   = 512,
  parameter int TCNT_W = 10,
  parameter int WID_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TCNT_W-1:0] launch_threads,
  input logic              launch_ready,
  input logic [NW-1:0]     warp_ready,
  input logic [NW-1:0]     warp_stall,
  input logic [NW-1:0]     warp_done,
  input logic              issue_valid,
  input logic [WID_W-1:0]  issue_warp,
  input logic [LANES-1:0]  issue_mask,
  input logic [NW-1:0]     warp_valid,
  input logic [NB-1:0]     blk_busy,
  input logic [NW-1:0]     elig
);

  AST_ISSUE_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (warp_ready[issue_warp] && !warp_stall[issue_warp])); // R4

  AST_ISSUE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> warp_valid[issue_warp]); // R4

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_mask != '0)); // R3

  AST_RR_REPEAT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid) && issue_warp == $past(issue_warp))
      |-> ($countones(elig) == 1)); // R5

  AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> !(&blk_busy)); // R8

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> (launch_threads != '0 && int'(launch_threads) <= MAXT)); // R10

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ((warp_done & warp_valid) != '0)
      |=> ((warp_valid & $past(warp_done & warp_valid)) == '0)); // R9

endmodule

bind warp_issue_sched wis_checker #(
  .NW(MAX_WARPS), .NB(MAX_BLOCKS), .LANES(LANES),
  .MAXT(MAX_BLOCK_THREADS), .TCNT_W(TCNT_W), .WID_W(WID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .launch_threads(launch_threads),
  .launch_ready  (launch_ready),
  .warp_ready    (warp_ready),
  .warp_stall    (warp_stall),
  .warp_done     (warp_done),
  .issue_valid   (issue_valid),
  .issue_warp    (issue_warp),
  .issue_mask    (issue_mask),
  .warp_valid    (warp_valid),
  .blk_busy      (blk_busy),
  .elig          (elig)
);

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;

  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch_valid;
  logic [9:0]    launch_threads;
  logic [31:0]   launch_pc;
  logic          launch_ready;
  logic [N-1:0]  warp_ready, warp_stall, warp_done;
  logic          issue_valid;
  logic [4:0]    issue_warp;
  logic [31:0]   issue_pc;
  logic [31:0]   issue_mask;

  always #10 clk = ~clk;

  warp_issue_sched dut (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_threads(launch_threads),
    .launch_pc(launch_pc), .launch_ready(launch_ready),
    .warp_ready(warp_ready), .warp_stall(warp_stall), .warp_done(warp_done),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_pc(issue_pc), .issue_mask(issue_mask)
  );

  typedef struct {
    bit          v;
    int          w;
    logic [31:0] pc;
    logic [31:0] m;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: queue what the issue port must show in the coming cycle
  task automatic cyc(input bit v, input int w, input logic [31:0] pc,
                     input logic [31:0] m, input string tag);
    exp_t e;
    e.v = v; e.w = w; e.pc = pc; e.m = m; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic lr(input bit e, input string tag);
    #4;
    check_val(tag, {31'd0, launch_ready}, {31'd0, e});
  endtask

  // monitor: compare before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check_val({e.tag, " valid"}, {31'd0, issue_valid}, {31'd0, e.v});
        if (e.v) begin
          check_val({e.tag, " warp"}, {27'd0, issue_warp}, e.w);
          check_val({e.tag, " pc"},   issue_pc, e.pc);
          check_val({e.tag, " mask"}, issue_mask, e.m);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  initial begin
    rst_n = 1'b0; launch_valid = 1'b0; launch_threads = 10'd32; launch_pc = '0;
    warp_ready = '1; warp_stall = '0; warp_done = '0;
    @(negedge clk);
    // R1: reset state
    lr(1'b1, "R1 launch_ready in reset");
    check_val("R1 issue_valid in reset", {31'd0, issue_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 issue_valid after reset", {31'd0, issue_valid}, 32'd0);
    warp_ready = '0;

    // R10: illegal sizes
    launch_threads = 10'd0;   lr(1'b0, "R10 zero threads");
    launch_threads = 10'd513; lr(1'b0, "R10 oversize");
    launch_threads = 10'd512; lr(1'b1, "R10 max size");
    @(negedge clk);

    // group A: 40 threads -> slots 0 (full) and 1 (8 lanes)
    launch_valid = 1'b1; launch_threads = 10'd40; launch_pc = 32'h100;
    cyc(0, 0, 0, 0, "R2 launch A");
    launch_valid = 1'b0;
    warp_ready = '1;
    cyc(1, 0, 32'h100, FULL,         "R2 A warp0");
    cyc(1, 1, 32'h100, 32'h0000_00FF, "R3 A tail");
    cyc(1, 0, 32'h104, FULL,         "R6 A warp0 step");
    cyc(1, 1, 32'h104, 32'h0000_00FF, "R6 A warp1 step");
    warp_stall = 24'h000001;
    cyc(1, 1, 32'h108, 32'h0000_00FF, "R4 stall bypass");
    warp_stall = 24'h000003;
    cyc(0, 0, 0, 0, "R4 all stalled");
    warp_stall = '0; warp_ready = '0;

    // group B: 512 threads -> slots 2..17
    launch_valid = 1'b1; launch_threads = 10'd512; launch_pc = 32'h200;
    lr(1'b1, "R7 B fits");
    cyc(0, 0, 0, 0, "R2 launch B");
    launch_threads = 10'd256; launch_pc = 32'h300;
    lr(1'b0, "R7 eight warps into six slots");
    cyc(0, 0, 0, 0, "R7 refused");
    launch_threads = 10'd192;
    lr(1'b1, "R7 six warps fit");
    cyc(0, 0, 0, 0, "R2 launch C");
    launch_valid = 1'b0;

    // R5: rotation after the last winner (warp 1)
    warp_ready = (24'd1 << 5) | (24'd1 << 20);
    cyc(1, 5,  32'h200, FULL, "R5 first after 1");
    cyc(1, 20, 32'h300, FULL, "R5 next after 5");
    cyc(1, 5,  32'h204, FULL, "R5 wrap after 20");
    warp_ready = '0;

    // R9: retire group A
    warp_done = 24'h000003;
    cyc(0, 0, 0, 0, "R9 retire A");
    warp_done = '0;
    launch_valid = 1'b1; launch_threads = 10'd64; launch_pc = 32'h400;
    lr(1'b1, "R9 slots of A reusable");
    cyc(0, 0, 0, 0, "R2 launch D");
    launch_valid = 1'b0;
    warp_done = 24'hFC0000;
    cyc(0, 0, 0, 0, "R9 retire C");
    warp_done = '0;

    // six single-thread groups -> slots 18..23, eight groups resident
    for (int k = 0; k < 6; k++) begin
      launch_valid = 1'b1; launch_threads = 10'd1; launch_pc = 32'h500 + 32'(k * 16);
      cyc(0, 0, 0, 0, "R8 fill groups");
    end
    launch_valid = 1'b0;
    warp_ready = 24'h800000;
    cyc(1, 23, 32'h550, 32'h1, "R3 single lane");
    warp_ready = '0;

    warp_done = 24'h000001;
    cyc(0, 0, 0, 0, "R9 D partly done");
    warp_done = '0;
    launch_valid = 1'b1; launch_threads = 10'd1; launch_pc = 32'h600;
    lr(1'b0, "R8 groups full");
    cyc(0, 0, 0, 0, "R8 refused");
    launch_valid = 1'b0;
    warp_done = 24'h000002;
    cyc(0, 0, 0, 0, "R9 D done");
    warp_done = '0;
    launch_valid = 1'b1;
    lr(1'b1, "R9 group slot freed");
    cyc(0, 0, 0, 0, "R9 launch E");
    launch_valid = 1'b0;
    warp_ready = 24'h000003;
    cyc(1, 0, 32'h600, 32'h1, "R9 lowest slot reused");
    warp_ready = 24'h000002;
    cyc(0, 0, 0, 0, "R9 retired slot silent");
    warp_ready = '0;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule